// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Generator with Majority-Vote Receive Sampler

This block turns the system clock into the bit timing of a serial port. It uses an 8-bit divisor X and a timer that repeats every X+1 count steps. In asynchronous mode the block emits a one-cycle oversample tick sixteen times per bit and a one-cycle bit tick once per bit. A speed select picks the divisor step: slow runs the timer once every 4 clocks, fast runs it on every clock. In synchronous master mode the timer runs on every clock, and the block drives a shift clock with a period of 4·(X+1) clocks. The speed select has no effect in that mode.

On the receive side, a helper tracks the oversample phase within the current bit. It samples the serial line at three consecutive oversample ticks around mid-bit and resolves the bit level by majority vote. A falling edge on the line, or a pulse on the resync input, restarts the phase. A divisor write restarts the timer at once, so the new rate takes effect without waiting for the old period to run out. With a 16 MHz clock, X = 25 and slow asynchronous mode, the bit rate is 16e6/1664 ≈ 9615 bit/s.

Top module: `serial_rate_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, ovsTick, bitTick and shiftClk are 0 and rxLevel is 1. Reset sets the divisor to 0.
- R2: Asynchronous slow mode (syncMode=0, fastSel=0): ovsTick pulses for one cycle every 4·(X+1) clocks, and bitTick pulses together with every 16th ovsTick, so bitTick repeats every 64·(X+1) clocks.
- R3: Asynchronous fast mode (syncMode=0, fastSel=1): ovsTick repeats every X+1 clocks and bitTick every 16·(X+1) clocks.
- R4: Synchronous mode (syncMode=1): shiftClk is a square wave with a period of 4·(X+1) clocks, each level lasting 2·(X+1) clocks. bitTick pulses in the cycle where shiftClk falls. ovsTick stays 0, and fastSel has no effect.
- R5: A write (divWrEn=1 at a clock edge) loads divWrData, clears the timer, the 4-clock prescaler and the shift clock, and produces no tick in the following cycle. The first ovsTick then appears exactly P·(X+1) cycles after the write edge, where P is 4 in slow mode and 1 otherwise.
- R6: With X=25 in asynchronous slow mode, bitTick repeats every 1664 clocks (9615 bit/s at 16 MHz).
- R7: The oversample phase counts ovsTicks 0..15 within a bit. The line is sampled at the ticks with phase 7, 8 and 9. One cycle after the phase-9 tick, rxLevel takes the majority of the three samples. rxLevel changes at no other time.
- R8: A falling edge on rxIn (high in one sampled cycle, low in the next) or resync=1 sets the phase to 0 for the next cycle. The next bitTick then follows the 16th oversample tick after the realignment.
- R9: In asynchronous mode shiftClk stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWrEn | input | 1 | Divisor write strobe |
| divWrData | input | 8 | New divisor value X |
| syncMode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| fastSel | input | 1 | Asynchronous speed select, 1 = fast (16 clocks per bit per step) |
| rxIn | input | 1 | Serial receive line (already synchronised to clk) |
| resync | input | 1 | Forces the oversample phase back to 0 |
| ovsTick | output | 1 | One-cycle oversample pulse |
| bitTick | output | 1 | One-cycle bit pulse |
| shiftClk | output | 1 | Synchronous shift clock |
| rxLevel | output | 1 | Majority-voted receive level |

## Verification
If the timer or the prescaler is off by one, the spacing between ticks changes, and the bench sees this at the first ovsTick, within P·(X+1) cycles. A wrong oversample phase moves bitTick and the instant at which rxLevel updates. The bench sees that within one bit time after a realignment. A reference model predicts all four outputs and is compared with them on every clock, so the first wrong cycle is reported. Directed measurements add checks on tick spacing, restart latency and the exact cycle of the vote.

// File: rtl/serial_rate_pkg.sv
package serial_rate_pkg;
  // Strobes from control to the divisor datapath
  typedef struct packed {
    logic step;   // advance the timer by one count
    logic clear;  // restart the timer at zero
  } timerCtl_t;
endpackage

// File: rtl/serial_rate_datapath.sv
module serial_rate_datapath
  import serial_rate_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCtl_t        ctl,
  input  logic             wrEn,
  input  logic [DIV_W-1:0] wrData,
  output logic             wrap
);
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] timer;
  logic             atTop;

  assign atTop = (timer == divReg);
  assign wrap  = ctl.step && !ctl.clear && atTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= '0;
      timer  <= '0;
    end else begin
      if (wrEn) divReg <= wrData;
      if (ctl.clear)     timer <= '0;
      else if (ctl.step) timer <= atTop ? '0 : timer + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rate_ctrl.sv
module serial_rate_ctrl
  import serial_rate_pkg::*;
#(
  parameter int OVS_RATE = 16,
  parameter int SLOW_PRE = 4,
  localparam int PHASE_W = $clog2(OVS_RATE),
  localparam int PRE_W   = (SLOW_PRE > 1) ? $clog2(SLOW_PRE) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               syncMode,
  input  logic               fastSel,
  input  logic               wrap,
  input  logic               rxIn,
  input  logic               resync,
  output timerCtl_t          ctl,
  output logic               ovsWrap,
  output logic [PHASE_W-1:0] phase,
  output logic               ovsTick,
  output logic               bitTick,
  output logic               shiftClk
);
  localparam logic [PRE_W-1:0]   PRE_LAST   = PRE_W'(SLOW_PRE - 1);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(OVS_RATE - 1);

  logic [PRE_W-1:0] preCnt;
  logic             halfFlag;
  logic             rxPrev;
  logic             realign;
  logic             bitNext;

  assign ctl.clear = wrEn;
  assign ctl.step  = syncMode || fastSel || (preCnt == PRE_LAST);
  assign ovsWrap   = wrap && !syncMode;
  assign realign   = resync || (rxPrev && !rxIn);
  assign bitNext   = syncMode ? (wrap && halfFlag && shiftClk)
                              : (ovsWrap && (phase == PHASE_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      halfFlag <= 1'b0;
      shiftClk <= 1'b0;
      phase    <= '0;
      rxPrev   <= 1'b1;
      ovsTick  <= 1'b0;
      bitTick  <= 1'b0;
    end else begin
      preCnt  <= (wrEn || preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      rxPrev  <= rxIn;
      ovsTick <= ovsWrap;
      bitTick <= bitNext;
      if (realign)      phase <= '0;
      else if (ovsWrap) phase <= phase + 1'b1;
      if (wrEn || !syncMode) begin
        halfFlag <= 1'b0;
        shiftClk <= 1'b0;
      end else if (wrap) begin
        halfFlag <= !halfFlag;
        if (halfFlag) shiftClk <= !shiftClk;
      end
    end
  end
endmodule

// File: rtl/serial_rate_sampler.sv
module serial_rate_sampler #(
  parameter int OVS_RATE   = 16,
  parameter int SAMPLE_MID = 8,
  localparam int PHASE_W   = $clog2(OVS_RATE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic [PHASE_W-1:0] phase,
  input  logic               rxIn,
  output logic               rxLevel
);
  localparam logic [PHASE_W-1:0] PH_A = PHASE_W'(SAMPLE_MID - 1);
  localparam logic [PHASE_W-1:0] PH_B = PHASE_W'(SAMPLE_MID);
  localparam logic [PHASE_W-1:0] PH_C = PHASE_W'(SAMPLE_MID + 1);

  logic sampA;
  logic sampB;
  logic vote;

  assign vote = (sampA & sampB) | (sampA & rxIn) | (sampB & rxIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampA   <= 1'b1;
      sampB   <= 1'b1;
      rxLevel <= 1'b1;
    end else if (sampleEn) begin
      if (phase == PH_A) sampA   <= rxIn;
      if (phase == PH_B) sampB   <= rxIn;
      if (phase == PH_C) rxLevel <= vote;
    end
  end
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import serial_rate_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int OVS_RATE   = 16,
  parameter int SLOW_PRE   = 4,
  parameter int SAMPLE_MID = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             syncMode,
  input  logic             fastSel,
  input  logic             rxIn,
  input  logic             resync,
  output logic             ovsTick,
  output logic             bitTick,
  output logic             shiftClk,
  output logic             rxLevel
);
  localparam int PHASE_W = $clog2(OVS_RATE);

  timerCtl_t          timerCtl;
  logic               timerWrap;
  logic               ovsWrap;
  logic [PHASE_W-1:0] phase;

  serial_rate_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(timerCtl), .wrEn(divWrEn),
    .wrData(divWrData), .wrap(timerWrap)
  );

  serial_rate_ctrl #(.OVS_RATE(OVS_RATE), .SLOW_PRE(SLOW_PRE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(divWrEn), .syncMode(syncMode),
    .fastSel(fastSel), .wrap(timerWrap), .rxIn(rxIn), .resync(resync),
    .ctl(timerCtl), .ovsWrap(ovsWrap), .phase(phase),
    .ovsTick(ovsTick), .bitTick(bitTick), .shiftClk(shiftClk)
  );

  serial_rate_sampler #(.OVS_RATE(OVS_RATE), .SAMPLE_MID(SAMPLE_MID)) u_vote (
    .clk(clk), .rstN(rstN), .sampleEn(ovsWrap), .phase(phase),
    .rxIn(rxIn), .rxLevel(rxLevel)
  );
endmodule

// File: rtl/serial_rate_chk.sv
module serial_rate_chk (
  input logic clk,
  input logic rstN,
  input logic divWrEn,
  input logic syncMode,
  input logic ovsTick,
  input logic bitTick,
  input logic shiftClk,
  input logic rxLevel
);
  // R2
  async_bit_with_ovs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !$past(syncMode)) |-> ovsTick);

  // R4
  sync_no_ovs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(syncMode) |-> !ovsTick);

  // R4
  sync_bit_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && $past(syncMode)) |-> $fell(shiftClk));

  // R9
  async_shift_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(syncMode) |-> !shiftClk);

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    divWrEn |=> (!ovsTick && !bitTick));

  // R7
  level_async_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxLevel) |-> !$past(syncMode));
endmodule

bind serial_rate_gen serial_rate_chk u_chk (
  .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .syncMode(syncMode),
  .ovsTick(ovsTick), .bitTick(bitTick), .shiftClk(shiftClk), .rxLevel(rxLevel)
);

// File: tb/serial_rate_gen_tb.sv
module serial_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       divWrEn = 1'b0;
  logic [7:0] divWrData = 8'd0;
  logic       syncMode = 1'b0;
  logic       fastSel = 1'b0;
  logic       rxIn = 1'b1;
  logic       resync = 1'b0;
  logic       ovsTick, bitTick, shiftClk, rxLevel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rate_gen u_dut (
    .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .divWrData(divWrData),
    .syncMode(syncMode), .fastSel(fastSel), .rxIn(rxIn), .resync(resync),
    .ovsTick(ovsTick), .bitTick(bitTick), .shiftClk(shiftClk), .rxLevel(rxLevel)
  );

  // Behavioural reference: clocks since the last restart, the tick index in the bit, a vote list
  int mN, mX, mPer, mPhase;
  bit mHalf, mPrev, mWrap, mOw, mRe;
  bit eOvs, eBit, eShift, eLevel;
  bit voteQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mN = 0; mX = 0; mPhase = 0; mHalf = 0; mPrev = 1;
      eOvs = 0; eBit = 0; eShift = 0; eLevel = 1;
      voteQ.delete();
    end else begin
      mPer  = (syncMode || fastSel) ? (mX + 1) : 4 * (mX + 1);
      mWrap = !divWrEn && (((mN + 1) % mPer) == 0);
      mOw   = mWrap && !syncMode;
      mRe   = resync || (mPrev && !rxIn);
      eOvs  = mOw;
      eBit  = syncMode ? (mWrap && mHalf && eShift) : (mOw && mPhase == 15);
      if (mOw && mPhase == 7) begin voteQ.delete(); voteQ.push_back(rxIn); end
      if (mOw && mPhase == 8) voteQ.push_back(rxIn);
      if (mOw && mPhase == 9) begin
        voteQ.push_back(rxIn);
        if (voteQ.size() == 3)
          eLevel = (int'(voteQ[0]) + int'(voteQ[1]) + int'(voteQ[2])) >= 2;
        voteQ.delete();
      end
      if (divWrEn || !syncMode) begin
        mHalf = 0; eShift = 0;
      end else if (mWrap) begin
        if (mHalf) eShift = !eShift;
        mHalf = !mHalf;
      end
      if (mRe) mPhase = 0;
      else if (mOw) mPhase = (mPhase + 1) % 16;
      mPrev = rxIn;
      if (divWrEn) begin mX = divWrData; mN = 0; end
      else mN = mN + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Compare every output with the reference on every clock
  always @(negedge clk) begin
    if (!done) begin
      check(ovsTick == eOvs, "R2/R3 ovsTick vs model", ovsTick, eOvs);
      check(bitTick == eBit, "R3/R8 bitTick vs model", bitTick, eBit);
      check(shiftClk == eShift, "R4/R9 shiftClk vs model", shiftClk, eShift);
      check(rxLevel == eLevel, "R7 rxLevel vs model", rxLevel, eLevel);
    end
  end

  task automatic writeDiv(input int v, input bit sm, input bit fs);
    @(negedge clk);
    divWrEn = 1'b1; divWrData = 8'(v); syncMode = sm; fastSel = fs;
    @(negedge clk);
    divWrEn = 1'b0;
  endtask

  function automatic bit pick(input int which);
    case (which)
      0: pick = ovsTick;
      1: pick = bitTick;
      default: pick = shiftClk;
    endcase
  endfunction

  // Clocks between two successive rises of the selected output
  task automatic gapOf(input int which, output int gap);
    int t0;
    bit last;
    t0 = -1; gap = -1;
    last = pick(which);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (pick(which) && !last) begin
        if (t0 < 0) t0 = cyc;
        else begin gap = cyc - t0; break; end
      end
      last = pick(which);
    end
  endtask

  initial begin
    int g, cnt, seen;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!ovsTick && !bitTick && !shiftClk, "R1 ticks low in reset", {ovsTick, bitTick, shiftClk}, 0);
    check(rxLevel == 1'b1, "R1 level idle high", rxLevel, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(!ovsTick && !bitTick && !shiftClk && rxLevel, "R1 first cycle after reset",
          {ovsTick, bitTick, shiftClk, rxLevel}, 1);

    // R2: slow asynchronous
    writeDiv(2, 0, 0);
    gapOf(0, g); check(g == 12, "R2 ovs spacing slow", g, 12);
    gapOf(1, g); check(g == 192, "R2 bit spacing slow", g, 192);

    // R3: fast asynchronous, R9 shift clock idle
    writeDiv(3, 0, 1);
    gapOf(0, g); check(g == 4, "R3 ovs spacing fast", g, 4);
    gapOf(1, g); check(g == 64, "R3 bit spacing fast", g, 64);
    seen = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (shiftClk) seen++; end
    check(seen == 0, "R9 shiftClk idle in async", seen, 0);

    // R4: synchronous mode, speed select ignored
    writeDiv(1, 1, 0);
    gapOf(2, g); check(g == 8, "R4 shift period", g, 8);
    gapOf(1, g); check(g == 8, "R4 bit spacing sync", g, 8);
    fastSel = 1'b1;
    gapOf(2, g); check(g == 8, "R4 shift period with fastSel", g, 8);
    seen = 0; cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ovsTick) seen++;
      if (shiftClk) cnt++;
    end
    check(seen == 0, "R4 no ovsTick in sync", seen, 0);
    check(cnt == 20, "R4 shiftClk duty", cnt, 20);

    // R5: a write restarts the timer at once
    writeDiv(3, 0, 1);
    repeat (2) @(negedge clk);
    @(negedge clk);
    divWrEn = 1'b1; divWrData = 8'd5;
    @(negedge clk);
    divWrEn = 1'b0;
    cnt = 0;
    while (!ovsTick && cnt < 50) begin cnt++; @(negedge clk); end
    check(cnt == 6, "R5 first tick after write", cnt, 6);

    // R6: 16 MHz / 9600 example
    writeDiv(25, 0, 0);
    gapOf(1, g); check(g == 1664, "R6 bit spacing X=25 slow", g, 1664);

    // R8: resync realigns the bit
    writeDiv(0, 0, 1);
    repeat (5) @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    repeat (15) @(negedge clk);
    check(bitTick == 1'b0, "R8 no bitTick at tick 15", bitTick, 0);
    @(negedge clk);
    check(bitTick == 1'b1, "R8 bitTick after 16 ticks", bitTick, 1);

    // R7: majority of ticks 7, 8, 9 (X=0 fast: one tick per clock)
    repeat (20) @(negedge clk);
    rxIn = 1'b0;                       // falling edge realigns
    @(negedge clk);                    // phase 0
    repeat (24) @(negedge clk);        // second bit, phase 8
    rxIn = 1'b1;                       // samples 0,1,1
    @(negedge clk);
    check(rxLevel == 1'b0, "R7 level before vote", rxLevel, 0);
    @(negedge clk);
    check(rxLevel == 1'b1, "R7 vote 0,1,1 gives 1", rxLevel, 1);
    rxIn = 1'b0;                       // new realigning edge
    @(negedge clk);
    repeat (9) @(negedge clk);         // phase 9
    rxIn = 1'b1;                       // samples 0,0,1
    @(negedge clk);
    check(rxLevel == 1'b0, "R7 vote 0,0,1 gives 0", rxLevel, 0);

    // Random line activity against the reference
    writeDiv(1, 0, 1);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      rxIn = 1'($urandom_range(0, 3) != 0);
      resync = ($urandom_range(0, 99) == 0);
    end
    resync = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule